// File: doc/BRIEF.md
# Bus-Cycle Wait-State and Ready Controller

This block paces one bus access at a time through the states T1, T2, T3 and T4. It inserts a programmed number of wait states (TW) between T3 and T4. It can also hold the access until an external ready input is seen.

The control fields of the addressed region are static inputs:

- a two-bit wait selector;
- an extended-count bit, which has an effect only on peripheral regions;
- a ready-enable bit.

The block latches these fields when a cycle starts.

There are two ready inputs:

- A synchronous ready pin is used as it is.
- An asynchronous ready pin first passes through a synchronizer chain.

Either pin being high counts as ready. The programmed wait states always run to completion before ready can close the cycle. When ready is enabled and missing at the sample point, the cycle parks in a wait state until ready arrives. At least two more wait states then follow before T4.

Top module: `bus_wait_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `bus_state` is IDLE (code 0) and `cycle_done` is low. The state codes are IDLE=0, T1=1, T2=2, T3=3, TW=4 and T4=5.
- R2: A high `cyc_start` seen in IDLE moves the state to T1 on that clock. The state then runs T1, T2, T3 on consecutive clocks. `cyc_start` has no effect in any state other than IDLE.
- R3: With `ext_sel` low, `wait_sel` values 0 to 3 insert exactly that many TW states. A cycle with ready disabled therefore lasts 4 + N clocks from T1 to T4.
- R4: On a peripheral region (region index 4 to 7 with the default mask) with `ext_sel` high, `wait_sel` 0, 1, 2 and 3 insert 5, 7, 9 and 15 wait states.
- R5: On a non-peripheral region (index 0 to 3), `ext_sel` is ignored, and the wait count is `wait_sel` alone.
- R6: With `rdy_en` low, neither ready input has any effect, and the cycle lasts exactly 4 + N clocks.
- R7: With `rdy_en` high and ready present at the sample point (the first TW), the cycle lasts 4 + N clocks.
- R8: With `rdy_en` high, N > 0 and ready absent at the first TW, the state stays TW until ready is seen. After the clock on which ready is seen, max(N-1, 2) further TW states follow, and then T4.
- R9: With `rdy_en` high and N = 0, ready is sampled in T3. If it is absent, T3 repeats until ready is seen, and then exactly two TW states precede T4.
- R10: `sync_rdy` acts on the clock it is sampled. `async_rdy` acts two clocks later than an equal level on `sync_rdy` would, because of the two-stage synchronizer. The two inputs are ORed.
- R11: `cycle_done` is high for exactly the one clock the state is T4. The next state is IDLE, and a start there is accepted on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Start-of-cycle strobe, honoured in IDLE |
| region_sel | input | REGION_W (3) | Index of the addressed chip-select region |
| wait_sel | input | 2 | Programmed wait-count selector |
| ext_sel | input | 1 | Extended wait table select (peripheral regions only) |
| rdy_en | input | 1 | Honour external ready for this region |
| async_rdy | input | 1 | Asynchronous active-high ready |
| sync_rdy | input | 1 | Synchronous active-high ready |
| bus_state | output | 3 | Current bus state code |
| cycle_done | output | 1 | One-clock pulse during T4 |

## Verification
The bench targets the following corner cases, and each one exposes a specific fault:

- **Late ready with N = 1, 2 or 3.** A design that skips the "at least two more waits" rule ends the cycle too early.
- **Late ready with N = 15.** A design that lets ready cut the programmed count short loses wait states.
- **Zero-wait cycle with ready enabled.** A controller that samples in the wrong state parks in TW instead of repeating T3.
- **Asynchronous ready.** A wrong synchronizer depth shifts the cycle end by a clock.
- **Extended bit on a memory region.** A decoder that ignores the region type produces a long cycle.
- **Start held high for a whole cycle.** A design that does not ignore start outside IDLE restarts mid-access.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5
   } bus_state_e;

   // wait states that always follow a late ready
   localparam int unsigned LATE_TAIL_WAITS = 2;

   // extended table for peripheral regions: 5, 7, 9, 15
   function automatic int unsigned ext_wait_count(input logic [1:0] sel);
      ext_wait_count = (sel == 2'b11) ? 15 : (5 + 2 * int'(sel));
   endfunction

endpackage

// File: rtl/bwc_rdy_sync.sv
module bwc_rdy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bwc_rdy_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_in};
   end

   assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/bwc_wait_decode.sv
module bwc_wait_decode
   import bwc_pkg::*;
#(
   parameter int unsigned                  REGION_W    = 3,
   parameter logic [(1<<REGION_W)-1:0]     PERIPH_MASK = 'hF0,
   parameter int unsigned                  CNT_W       = 4,
   parameter bit                           EXT_EN      = 1'b1
) (
   input  logic [REGION_W-1:0] region_sel,
   input  logic [1:0]          wait_sel,
   input  logic                ext_sel,
   output logic [CNT_W-1:0]    wait_n
);

   if (CNT_W < 4) begin : g_bad_cnt
      $error("bwc_wait_decode: CNT_W must hold 15");
   end

   logic [CNT_W-1:0] base_n;
   assign base_n = CNT_W'(wait_sel);

   if (EXT_EN) begin : g_ext
      logic             periph;
      logic [CNT_W-1:0] long_n;
      assign periph = PERIPH_MASK[region_sel];
      assign long_n = CNT_W'(ext_wait_count(wait_sel));
      assign wait_n = (periph && ext_sel) ? long_n : base_n;
   end else begin : g_basic
      logic unused_ext;
      assign unused_ext = ext_sel ^ (|region_sel);
      assign wait_n     = base_n;
   end

endmodule

// File: rtl/bwc_sequencer.sv
module bwc_sequencer
   import bwc_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] wait_n,
   input  logic             rdy_en,
   input  logic             rdy,
   output bus_state_e       state,
   output logic             done
);

   localparam logic [CNT_W-1:0] TAIL = CNT_W'(LATE_TAIL_WAITS);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   bus_state_e       st_q, st_d;
   logic [CNT_W-1:0] rem_q, rem_d;
   logic             hold_q, hold_d;
   logic             smp_q, smp_d;
   logic             ren_q, ren_d;
   logic             done_q;
   logic             rdy_ok;
   logic [CNT_W-1:0] rem_dec;

   assign rdy_ok  = !ren_q || rdy;
   assign rem_dec = rem_q - ONE;

   always_comb begin
      st_d   = st_q;
      rem_d  = rem_q;
      hold_d = hold_q;
      smp_d  = smp_q;
      ren_d  = ren_q;
      unique case (st_q)
         ST_IDLE: if (start) begin
            st_d   = ST_T1;
            rem_d  = wait_n;
            ren_d  = rdy_en;
            hold_d = 1'b0;
            smp_d  = 1'b0;
         end
         ST_T1: st_d = ST_T2;
         ST_T2: begin
            st_d  = ST_T3;
            smp_d = 1'b1;
         end
         ST_T3: begin
            if (rem_q != '0) begin
               st_d = ST_TW;
            end else if (hold_q) begin
               if (rdy) begin
                  hold_d = 1'b0;
                  rem_d  = TAIL;
                  st_d   = ST_TW;
               end
            end else if (smp_q && !rdy_ok) begin
               hold_d = 1'b1;
               smp_d  = 1'b0;
            end else begin
               smp_d = 1'b0;
               st_d  = ST_T4;
            end
         end
         ST_TW: begin
            if (hold_q) begin
               if (rdy) begin
                  hold_d = 1'b0;
                  rem_d  = (rem_dec > TAIL) ? rem_dec : TAIL;
               end
            end else if (smp_q && !rdy_ok) begin
               hold_d = 1'b1;
               smp_d  = 1'b0;
            end else begin
               smp_d = 1'b0;
               if (rem_q <= ONE) st_d  = ST_T4;
               else              rem_d = rem_dec;
            end
         end
         ST_T4:   st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         rem_q  <= '0;
         hold_q <= 1'b0;
         smp_q  <= 1'b0;
         ren_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         rem_q  <= rem_d;
         hold_q <= hold_d;
         smp_q  <= smp_d;
         ren_q  <= ren_d;
         done_q <= (st_d == ST_T4);
      end
   end

   assign state = st_q;
   assign done  = done_q;

   assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_T1 |=> st_q == ST_T2);

   assert_busy_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != ST_IDLE |=> st_q != ST_T1);

   assert_done_in_t4_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> st_q == ST_T4);

   assert_t4_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_T4 |=> (st_q == ST_IDLE && !done_q));

   assert_hold_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |-> ren_q);

   assert_wait_has_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TW && !hold_q) |-> rem_q != '0);

   assert_hold_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && !rdy) |=> $stable(st_q));

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
   import bwc_pkg::*;
#(
   parameter int unsigned              REGION_W    = 3,
   parameter logic [(1<<REGION_W)-1:0] PERIPH_MASK = 'hF0,
   parameter int unsigned              CNT_W       = 4,
   parameter int unsigned              SYNC_STAGES = 2,
   parameter bit                       EXT_EN      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cyc_start,
   input  logic [REGION_W-1:0] region_sel,
   input  logic [1:0]          wait_sel,
   input  logic                ext_sel,
   input  logic                rdy_en,
   input  logic                async_rdy,
   input  logic                sync_rdy,
   output logic [2:0]          bus_state,
   output logic                cycle_done
);

   if (REGION_W < 1 || REGION_W > 6) begin : g_bad_region
      $error("bus_wait_ctrl: REGION_W out of range");
   end

   logic             async_s;
   logic             rdy_any;
   logic [CNT_W-1:0] wait_n;
   bus_state_e       st;

   bwc_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (async_rdy),
      .sync_out (async_s)
   );

   assign rdy_any = async_s | sync_rdy;

   bwc_wait_decode #(
      .REGION_W    (REGION_W),
      .PERIPH_MASK (PERIPH_MASK),
      .CNT_W       (CNT_W),
      .EXT_EN      (EXT_EN)
   ) u_dec (
      .region_sel (region_sel),
      .wait_sel   (wait_sel),
      .ext_sel    (ext_sel),
      .wait_n     (wait_n)
   );

   bwc_sequencer #(.CNT_W(CNT_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cyc_start),
      .wait_n (wait_n),
      .rdy_en (rdy_en),
      .rdy    (rdy_any),
      .state  (st),
      .done   (cycle_done)
   );

   assign bus_state = st;

   assert_start_goes_t1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && cyc_start) |=> bus_state == 3'd1);

   assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_state <= 3'd5);

endmodule

// File: tb/bus_wait_ctrl_test.sv
`timescale 1ns/1ps
module bus_wait_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_start = 1'b0;
   logic [2:0] region_sel = '0;
   logic [1:0] wait_sel = '0;
   logic       ext_sel = 1'b0;
   logic       rdy_en = 1'b0;
   logic       async_rdy = 1'b0;
   logic       sync_rdy = 1'b0;
   logic [2:0] bus_state;
   logic       cycle_done;

   int vectors = 0;
   int errors  = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   bus_wait_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_start  (cyc_start),
      .region_sel (region_sel),
      .wait_sel   (wait_sel),
      .ext_sel    (ext_sel),
      .rdy_en     (rdy_en),
      .async_rdy  (async_rdy),
      .sync_rdy   (sync_rdy),
      .bus_state  (bus_state),
      .cycle_done (cycle_done)
   );

   // behavioural reference: phase number plus counters
   int phase = 0;        // 0 idle,1..3 T1..T3,4 wait,5 T4
   int waits_left = 0;
   bit parked = 0;
   bit probe = 0;
   bit honour = 0;
   bit [1:0] apipe = '0;

   function automatic int want_waits(input logic [2:0] reg_i, input logic [1:0] ws,
                                     input logic ex);
      int tbl[4] = '{5, 7, 9, 15};
      if (ex && reg_i >= 3'd4) return tbl[ws];
      return int'(ws);
   endfunction

   always @(posedge clk) begin
      bit seen;
      bit ok;
      seen  = sync_rdy | apipe[1];
      apipe = {apipe[0], async_rdy};
      ok    = !honour || seen;
      if (!rst_n) begin
         phase = 0; waits_left = 0; parked = 0; probe = 0; honour = 0; apipe = '0;
      end else begin
         case (phase)
            0: if (cyc_start) begin
                  phase = 1;
                  waits_left = want_waits(region_sel, wait_sel, ext_sel);
                  honour = rdy_en; parked = 0; probe = 0;
               end
            1: phase = 2;
            2: begin phase = 3; probe = 1; end
            3: begin
                  if (waits_left > 0) phase = 4;
                  else if (parked) begin
                     if (seen) begin parked = 0; waits_left = 2; phase = 4; end
                  end else if (probe && !ok) begin parked = 1; probe = 0; end
                  else begin probe = 0; phase = 5; end
               end
            4: begin
                  if (parked) begin
                     if (seen) begin
                        parked = 0;
                        waits_left = (waits_left - 1 > 2) ? waits_left - 1 : 2;
                     end
                  end else if (probe && !ok) begin parked = 1; probe = 0; end
                  else begin
                     probe = 0;
                     waits_left = waits_left - 1;
                     if (waits_left <= 0) phase = 5;
                  end
               end
            default: phase = 0;
         endcase
      end
   end

   task automatic compare();
      vectors++;
      if (bus_state !== 3'(phase) || cycle_done !== (phase == 5)) begin
         errors++;
         $display("FAIL %s: state=%0d done=%0b expected state=%0d done=%0b",
                  cur_req, bus_state, cycle_done, phase, (phase == 5));
      end
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
   endtask

   // one access: ready rises 'delay' clocks after start (0 = from start)
   task automatic run(input string tag, input logic [2:0] rg, input logic [1:0] ws,
                      input logic ex, input logic en, input int delay,
                      input bit use_async, input bit keep_start);
      cur_req = tag;
      region_sel = rg; wait_sel = ws; ext_sel = ex; rdy_en = en;
      cyc_start = 1'b1;
      if (use_async) async_rdy = (delay == 0); else sync_rdy = (delay == 0);
      for (int k = 1; k < 200; k++) begin
         tick();
         if (phase == 5) begin
            cyc_start = 1'b0; async_rdy = 1'b0; sync_rdy = 1'b0;
            tick();
            break;
         end
         if (use_async) async_rdy = (k >= delay); else sync_rdy = (k >= delay);
         if (!keep_start) cyc_start = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      cur_req = "R1";
      repeat (3) tick();
      @(negedge clk); rst_n = 1'b1;
      tick();
      // R3 basic counts, ready disabled
      for (int w = 0; w < 4; w++) run("R3", 3'd1, 2'(w), 1'b0, 1'b0, 0, 1'b0, 1'b0);
      // R4 extended table on peripheral region
      for (int w = 0; w < 4; w++) run("R4", 3'd5, 2'(w), 1'b1, 1'b0, 0, 1'b0, 1'b0);
      // R5 extended bit ignored on memory region
      run("R5", 3'd2, 2'd2, 1'b1, 1'b0, 0, 1'b0, 1'b0);
      run("R5", 3'd3, 2'd3, 1'b1, 1'b1, 0, 1'b0, 1'b0);
      // R6 ready disabled: late ready ignored
      run("R6", 3'd1, 2'd2, 1'b0, 1'b0, 50, 1'b0, 1'b0);
      run("R6", 3'd1, 2'd0, 1'b0, 1'b0, 50, 1'b1, 1'b0);
      // R7 ready present at sample
      run("R7", 3'd0, 2'd3, 1'b0, 1'b1, 0, 1'b0, 1'b0);
      run("R7", 3'd0, 2'd1, 1'b0, 1'b1, 4, 1'b0, 1'b0);
      // R8 late ready
      run("R8", 3'd0, 2'd3, 1'b0, 1'b1, 8, 1'b0, 1'b0);
      run("R8", 3'd0, 2'd1, 1'b0, 1'b1, 7, 1'b0, 1'b0);
      run("R8", 3'd0, 2'd2, 1'b0, 1'b1, 6, 1'b0, 1'b0);
      run("R8", 3'd6, 2'd3, 1'b1, 1'b1, 10, 1'b0, 1'b0);
      // R9 zero waits, ready sampled in T3
      run("R9", 3'd1, 2'd0, 1'b0, 1'b1, 6, 1'b0, 1'b0);
      run("R9", 3'd1, 2'd0, 1'b0, 1'b1, 0, 1'b0, 1'b0);
      // R10 asynchronous ready through synchronizer
      run("R10", 3'd2, 2'd1, 1'b0, 1'b1, 5, 1'b1, 1'b0);
      run("R10", 3'd2, 2'd1, 1'b0, 1'b1, 0, 1'b1, 1'b0);
      run("R10", 3'd2, 2'd0, 1'b0, 1'b1, 2, 1'b1, 1'b0);
      // R2 / R11 start held high, then back-to-back restart
      run("R2", 3'd4, 2'd2, 1'b0, 1'b0, 0, 1'b0, 1'b1);
      run("R11", 3'd4, 2'd1, 1'b0, 1'b0, 0, 1'b0, 1'b1);
      cur_req = "R11";
      repeat (3) tick();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule